// File: doc/BRIEF.md
# Cascaded Prioritized Interrupt Controller

This block gathers level-sensitive interrupt requests from two local groups of eight sources each and from one shared group of eight mapped sources. It reduces them to a single interrupt line and a source code for a processor. The mapped group has one status input and two independent enable masks. Each local group reserves one of its bits as a cascade from the mapped group. When that cascade bit is pending, the local group reports a mapped source in place of its own bits.

Above the two local groups sits a fixed-order arbiter. It also sees a high-priority timer line, a bus-error line and two low-priority timer lines. Only one winner is reported at a time. A request that loses stays visible at the inputs and is reported once the winner drops. Software reaches the four mask registers through a small address/data port with a write strobe. The block does not latch edges and does not clear sources.

Top module: `casc_irq_ctrl`

## Requirements
- R1: While reset is low, and right after it is released, all four masks read as zero, `irq_o` is low and `vec_o` is 0. With every mask at zero, no status input can raise an interrupt.
- R2: A write with `reg_we_i` high loads `reg_wdata_i` into the mask selected by `reg_addr_i` at the next clock edge. The addresses are 0 = local mask 0, 1 = local mask 1, 2 = mapped mask 0 and 3 = mapped mask 1. `reg_rdata_o` always shows the mask selected by `reg_addr_i`. Masks that are not written keep their value.
- R3: A local group is pending only for bits set in both its status input and its local mask. Status bits whose mask bit is clear have no effect on `vec_o`.
- R4: Within a group, the highest-numbered pending bit wins. Local group 0 bit b reports code 1+b. Local group 1 bit b reports code 9+b.
- R5: Local group 0 bit 2 is its cascade. When that bit is pending, the group reports the highest set bit b of (mapped status AND mapped mask 0) as code 17+b, even if higher local bits are also pending.
- R6: Local group 1 bit 3 is its cascade. When that bit is pending, the group reports the highest set bit b of (the same mapped status AND mapped mask 1) as code 25+b.
- R7: A pending cascade bit with a zero masked mapped vector yields code 0 and `irq_o` low. Lower-priority requests are not reported in its place.
- R8: The processor-level order, highest first, is: high-priority timer (code 33), local group 0, local group 1, bus error (code 34), then the low-priority timers.
- R9: `irq_o` is high exactly when `vec_o` is nonzero. Both are registered and reflect the inputs and masks present at the previous clock edge.
- R10: A request that loses arbitration is reported as soon as the winner is withdrawn.
- R11: Low-priority timer 0 (code 35) wins over low-priority timer 1 (code 36).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loc0_stat_i | input | 8 | Local group 0 request levels |
| loc1_stat_i | input | 8 | Local group 1 request levels |
| map_stat_i | input | 8 | Shared mapped group request levels |
| tmr_hi_i | input | 1 | High-priority timer request |
| bus_err_i | input | 1 | Bus-error request |
| tmr_lo_i | input | 2 | Low-priority timer requests, bit 0 ranks above bit 1 |
| reg_we_i | input | 1 | Mask write strobe |
| reg_addr_i | input | 2 | Mask register select |
| reg_wdata_i | input | 8 | Mask write data |
| reg_rdata_o | output | 8 | Selected mask contents |
| irq_o | output | 1 | Interrupt to the processor |
| vec_o | output | 6 | Code of the reported source, 0 when none |

## Verification
An input change applied before clock edge k shows up on `vec_o` and `irq_o` just after edge k. A mask write strobed at edge k changes the mask at k, affects the read port at once, and affects the vector only from edge k+1. The bench reference model follows the same timing. At each rising edge it first computes the expected code from the inputs and its current mask copies, and only then applies the write. All comparisons are made at the falling edge, half a period after the registers update. Stimulus changes one time unit after that falling edge, so sampling and driving never share an instant.

// File: rtl/casc_irq_pkg.sv
// Package: shared sizing helpers and fixed code assignments for the
// cascaded interrupt controller. Assumes every group has the same width.
package casc_irq_pkg;

    // Code of local group g bit 0.
    function automatic int loc_base(input int w, input int g);
        return 1 + g * w;
    endfunction

    // Code of mapped bit 0 when seen through mapped mask g.
    function automatic int map_base(input int w, input int g);
        return 1 + 2 * w + g * w;
    endfunction

    // Fixed codes placed after the four group ranges.
    function automatic int code_tmr_hi(input int w);
        return 4 * w + 1;
    endfunction

    function automatic int code_bus_err(input int w);
        return 4 * w + 2;
    endfunction

    function automatic int code_tmr_lo(input int w, input int i);
        return 4 * w + 3 + i;
    endfunction

    // Vector width that holds every code.
    function automatic int vec_width(input int w);
        return $clog2(4 * w + 5);
    endfunction

endpackage

// File: rtl/irq_prio_enc.sv
// Module: highest-index-first priority encoder.
// Assumes: W >= 2. idx is 0 when no request is set; use any to qualify it.
module irq_prio_enc #(
    parameter int W  = 8,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan upward so the last (highest) set bit is kept.
    always_comb begin
        any = |req;
        idx = '0;
        for (int b = 0; b < W; b++) begin
            if (req[b]) idx = IW'(b);
        end
    end
endmodule

// File: rtl/irq_mask_bank.sv
// Module: four enable-mask registers behind a write-strobe port.
// Assumes: synchronous active-low reset clears every mask; read is combinational.
module irq_mask_bank #(
    parameter int W     = 8,
    parameter int NREG  = 4,
    parameter int AW    = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [AW-1:0]          addr,
    input  logic [W-1:0]           wdata,
    output logic [W-1:0]           rdata,
    output logic [NREG-1:0][W-1:0] masks
);
    // One register per mask, each loads only when addressed.
    for (genvar r = 0; r < NREG; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)                         masks[r] <= '0;
            else if (we && addr == AW'(r))      masks[r] <= wdata;
        end
    end

    // Read mux for the selected mask.
    always_comb rdata = masks[addr];

    AST_MASK_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> masks[$past(addr)] == $past(wdata)); // R2
    AST_MASK_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(masks)); // R2
    AST_MASK_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> masks == '0); // R1
endmodule

// File: rtl/irq_group_resolve.sv
// Module: resolves one local group, substituting the mapped group when its
// cascade bit is pending. Assumes CASC < W and the code bases fit in VW bits.
module irq_group_resolve #(
    parameter int W     = 8,
    parameter int CASC  = 2,
    parameter int LBASE = 1,
    parameter int MBASE = 17,
    parameter int VW    = 6
) (
    input  logic [W-1:0]  stat,
    input  logic [W-1:0]  mask,
    input  logic [W-1:0]  map_stat,
    input  logic [W-1:0]  map_mask,
    output logic          pend,
    output logic [VW-1:0] vec
);
    localparam int IW = $clog2(W);

    logic [W-1:0]  loc_req, map_req;
    logic          loc_any, map_any;
    logic [IW-1:0] loc_idx, map_idx;

    // Effective pending vectors of the local and mapped levels.
    always_comb begin
        loc_req = stat & mask;
        map_req = map_stat & map_mask;
    end

    irq_prio_enc #(.W(W)) u_loc_enc (.req(loc_req), .any(loc_any), .idx(loc_idx));
    irq_prio_enc #(.W(W)) u_map_enc (.req(map_req), .any(map_any), .idx(map_idx));

    // Pick cascade result ahead of any local bit, else the top local bit.
    always_comb begin
        pend = loc_any;
        if (!loc_any)           vec = '0;
        else if (loc_req[CASC]) vec = map_any ? VW'(MBASE) + VW'(map_idx) : '0;
        else                    vec = VW'(LBASE) + VW'(loc_idx);
    end
endmodule

// File: rtl/irq_cpu_arb.sv
// Module: fixed-order processor-level arbiter over the group results and
// the timer and bus-error lines. A pending group wins even if it resolves to 0.
module irq_cpu_arb
    import casc_irq_pkg::*;
#(
    parameter int W  = 8,
    parameter int VW = vec_width(W)
) (
    input  logic                 tmr_hi,
    input  logic [1:0]           grp_pend,
    input  logic [1:0][VW-1:0]   grp_vec,
    input  logic                 bus_err,
    input  logic [1:0]           tmr_lo,
    output logic                 hit,
    output logic [VW-1:0]        vec
);
    // Strict priority chain; hit flags a real source rather than an empty cascade.
    always_comb begin
        hit = 1'b1;
        if (tmr_hi)            vec = VW'(code_tmr_hi(W));
        else if (grp_pend[0])  begin vec = grp_vec[0]; hit = |grp_vec[0]; end
        else if (grp_pend[1])  begin vec = grp_vec[1]; hit = |grp_vec[1]; end
        else if (bus_err)      vec = VW'(code_bus_err(W));
        else if (tmr_lo[0])    vec = VW'(code_tmr_lo(W, 0));
        else if (tmr_lo[1])    vec = VW'(code_tmr_lo(W, 1));
        else                   begin vec = '0; hit = 1'b0; end
    end
endmodule

// File: rtl/casc_irq_ctrl.sv
// Module: top of the cascaded interrupt controller. Holds the mask bank,
// two group resolvers sharing one mapped status, the arbiter and the
// registered outputs. Assumes level inputs already synchronous to clk.
module casc_irq_ctrl
    import casc_irq_pkg::*;
#(
    parameter int GRP_W     = 8,
    parameter int CASC0_BIT = 2,
    parameter int CASC1_BIT = 3,
    parameter int VW        = vec_width(GRP_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GRP_W-1:0] loc0_stat_i,
    input  logic [GRP_W-1:0] loc1_stat_i,
    input  logic [GRP_W-1:0] map_stat_i,
    input  logic             tmr_hi_i,
    input  logic             bus_err_i,
    input  logic [1:0]       tmr_lo_i,
    input  logic             reg_we_i,
    input  logic [1:0]       reg_addr_i,
    input  logic [GRP_W-1:0] reg_wdata_i,
    output logic [GRP_W-1:0] reg_rdata_o,
    output logic             irq_o,
    output logic [VW-1:0]    vec_o
);
    localparam int NGRP = 2;

    logic [3:0][GRP_W-1:0]      masks;
    logic [NGRP-1:0][GRP_W-1:0] loc_stat;
    logic [NGRP-1:0]            grp_pend;
    logic [NGRP-1:0][VW-1:0]    grp_vec;
    logic                       arb_hit;
    logic [VW-1:0]              arb_vec;

    // Bundle the local status inputs for the generate loop.
    always_comb loc_stat = {loc1_stat_i, loc0_stat_i};

    irq_mask_bank #(.W(GRP_W), .NREG(4)) u_masks (
        .clk(clk), .rst_n(rst_n), .we(reg_we_i), .addr(reg_addr_i),
        .wdata(reg_wdata_i), .rdata(reg_rdata_o), .masks(masks)
    );

    // Masks 0/1 are local, 2/3 are mapped; group g pairs with mapped mask g.
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int CP = (g == 0) ? CASC0_BIT : CASC1_BIT;
        irq_group_resolve #(
            .W(GRP_W), .CASC(CP), .LBASE(loc_base(GRP_W, g)),
            .MBASE(map_base(GRP_W, g)), .VW(VW)
        ) u_res (
            .stat(loc_stat[g]), .mask(masks[g]), .map_stat(map_stat_i),
            .map_mask(masks[2 + g]), .pend(grp_pend[g]), .vec(grp_vec[g])
        );
    end

    irq_cpu_arb #(.W(GRP_W), .VW(VW)) u_arb (
        .tmr_hi(tmr_hi_i), .grp_pend(grp_pend), .grp_vec(grp_vec),
        .bus_err(bus_err_i), .tmr_lo(tmr_lo_i), .hit(arb_hit), .vec(arb_vec)
    );

    // Output register: one cycle from inputs or masks to the processor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            vec_o <= '0;
        end else begin
            irq_o <= arb_hit;
            vec_o <= arb_vec;
        end
    end

    localparam int MB0 = map_base(GRP_W, 0);

    AST_IRQ_FOLLOWS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (vec_o != '0)); // R9
    AST_HI_TIMER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_hi_i |=> vec_o == VW'(code_tmr_hi(GRP_W))); // R8
    AST_CASC0_SUBST: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_hi_i && loc0_stat_i[CASC0_BIT] && masks[0][CASC0_BIT] && |(map_stat_i & masks[2]))
        |=> (vec_o >= VW'(MB0) && vec_o < VW'(MB0 + GRP_W))); // R5
    AST_CASC0_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_hi_i && loc0_stat_i[CASC0_BIT] && masks[0][CASC0_BIT] && !(|(map_stat_i & masks[2])))
        |=> !irq_o); // R7
endmodule

// File: tb/tb_casc_irq_ctrl.sv
// Bench: behavioural reference model updated on each rising edge, compared
// with the outputs on each falling edge.
module tb_casc_irq_ctrl;
    localparam int CLK_P = 10;
    localparam int C0 = 2;
    localparam int C1 = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] l0 = '0, l1 = '0, mp = '0;
    logic th = 1'b0, be = 1'b0;
    logic [1:0] tl = '0;
    logic we = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic irq;
    logic [5:0] vec;

    int checks = 0, errors = 0;
    string cur_req = "R1";
    logic [7:0] m [4];
    int exp_vec = 0;
    bit started = 0, done = 0;

    casc_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .loc0_stat_i(l0), .loc1_stat_i(l1),
        .map_stat_i(mp), .tmr_hi_i(th), .bus_err_i(be), .tmr_lo_i(tl),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq), .vec_o(vec)
    );

    always #(CLK_P/2) clk = ~clk;

    // Highest set bit of a byte, -1 if none.
    function automatic int top_bit(input logic [7:0] v);
        for (int b = 7; b >= 0; b--) if (v[b]) return b;
        return -1;
    endfunction

    // Group result: -1 when not pending, else the code (0 for empty cascade).
    function automatic int grp(input logic [7:0] s, input logic [7:0] mk,
                               input logic [7:0] mm, input int casc,
                               input int lb, input int mb);
        logic [7:0] p;
        int t;
        p = s & mk;
        if (p == 0) return -1;
        if (p[casc]) begin
            t = top_bit(mp & mm);
            return (t < 0) ? 0 : mb + t;
        end
        return lb + top_bit(p);
    endfunction

    always @(posedge clk) begin
        int g0, g1;
        started = 1;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m[i] = '0;
            exp_vec = 0;
        end else begin
            g0 = grp(l0, m[0], m[2], C0, 1, 17);
            g1 = grp(l1, m[1], m[3], C1, 9, 25);
            if (th)          exp_vec = 33;
            else if (g0 >= 0) exp_vec = g0;
            else if (g1 >= 0) exp_vec = g1;
            else if (be)     exp_vec = 34;
            else if (tl[0])  exp_vec = 35;
            else if (tl[1])  exp_vec = 36;
            else             exp_vec = 0;
            if (we) m[addr] = wdata;
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (int'(vec) != exp_vec) begin
                errors++;
                $display("FAIL %s vec_o act=%0d exp=%0d at %0t", cur_req, vec, exp_vec, $time);
            end
            checks++;
            if (irq !== (exp_vec != 0)) begin
                errors++;
                $display("FAIL %s irq_o act=%0b exp=%0b at %0t", cur_req, irq, exp_vec != 0, $time);
            end
            checks++;
            if (rdata !== (rst_n ? m[addr] : 8'h00) && rst_n) begin
                errors++;
                $display("FAIL %s reg_rdata_o act=%0h exp=%0h at %0t", cur_req, rdata, m[addr], $time);
            end
        end
    end

    task automatic drive(input logic [7:0] a0, input logic [7:0] a1, input logic [7:0] am,
                         input logic h, input logic b, input logic [1:0] lo,
                         input int n, input string req);
        @(negedge clk); #1;
        cur_req = req;
        l0 = a0; l1 = a1; mp = am; th = h; be = b; tl = lo;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input string req);
        @(negedge clk); #1;
        cur_req = req;
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk); #1;
        we = 1'b0;
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog act=timeout exp=finish");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state, then all-ones statuses with zero masks
        repeat (3) @(negedge clk);
        drive(8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0, 2'b00, 1, "R1");
        #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R2: load masks and read each back
        drive(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 2'b00, 1, "R2");
        wr(2'd0, 8'h11, "R2");
        wr(2'd1, 8'h22, "R2");
        wr(2'd2, 8'h81, "R2");
        wr(2'd3, 8'h18, "R2");
        for (int a = 0; a < 4; a++) begin
            @(negedge clk); #1 addr = 2'(a);
        end
        // R3: masked-off bits ignored, enabled bit seen
        drive(8'hEE, 8'h00, 8'h00, 1'b0, 1'b0, 2'b00, 3, "R3");
        drive(8'h10, 8'h00, 8'h00, 1'b0, 1'b0, 2'b00, 3, "R3");
        // R4: highest bit wins in each local group
        wr(2'd0, 8'hFB, "R4");
        drive(8'hFB, 8'h00, 8'h00, 1'b0, 1'b0, 2'b00, 3, "R4");
        drive(8'h03, 8'h00, 8'h00, 1'b0, 1'b0, 2'b00, 3, "R4");
        drive(8'h01, 8'h00, 8'h00, 1'b0, 1'b0, 2'b00, 3, "R4");
        wr(2'd1, 8'hF7, "R4");
        drive(8'h00, 8'h60, 8'h00, 1'b0, 1'b0, 2'b00, 3, "R4");
        // R5: cascade bit of group 0 overrides its higher bits
        wr(2'd0, 8'hFF, "R5");
        drive(8'h84, 8'h00, 8'h01, 1'b0, 1'b0, 2'b00, 3, "R5");
        drive(8'h84, 8'h00, 8'hFF, 1'b0, 1'b0, 2'b00, 3, "R5");
        // R7: empty cascade blocks lower sources
        drive(8'h84, 8'h60, 8'h10, 1'b0, 1'b1, 2'b11, 3, "R7");
        // R6: group 1 cascade through the second mapped mask
        wr(2'd1, 8'hFF, "R6");
        drive(8'h00, 8'h88, 8'h10, 1'b0, 1'b0, 2'b00, 3, "R6");
        drive(8'h00, 8'h08, 8'h08, 1'b0, 1'b0, 2'b00, 3, "R6");
        drive(8'h00, 8'h08, 8'h81, 1'b0, 1'b0, 2'b00, 3, "R7");
        // R8: priority ladder, peeling off winners
        drive(8'h02, 8'h40, 8'h00, 1'b1, 1'b1, 2'b11, 3, "R8");
        drive(8'h02, 8'h40, 8'h00, 1'b0, 1'b1, 2'b11, 3, "R8");
        // R10: loser shown once the winner clears
        drive(8'h00, 8'h40, 8'h00, 1'b0, 1'b1, 2'b11, 3, "R10");
        drive(8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 2'b11, 3, "R10");
        // R11: low timers ordered
        drive(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 2'b11, 3, "R11");
        drive(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 2'b10, 3, "R11");
        // R9: single-cycle toggles of the output
        for (int i = 0; i < 6; i++) begin
            drive(8'h00, 8'h00, 8'h00, 1'(i % 2), 1'b0, 2'b00, 1, "R9");
        end
        // R2: mask change while a source is held
        drive(8'h20, 8'h00, 8'h00, 1'b0, 1'b0, 2'b00, 2, "R2");
        wr(2'd0, 8'h00, "R2");
        drive(8'h20, 8'h00, 8'h00, 1'b0, 1'b0, 2'b00, 2, "R3");
        // R8: random mix with writes
        for (int i = 0; i < 400; i++) begin
            @(negedge clk); #1;
            cur_req = "R8";
            l0 = 8'($urandom); l1 = 8'($urandom); mp = 8'($urandom);
            th = ($urandom % 8) == 0; be = 1'($urandom); tl = 2'($urandom);
            we = ($urandom % 4) == 0; addr = 2'($urandom); wdata = 8'($urandom);
        end
        @(negedge clk); #1 we = 1'b0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule